// File: doc/BRIEF.md
# Double-Density Disk Read Decoder with Sync-Mark Framing

This block turns the raw pulse train from a double-density disk read head into bytes. The pulses are active-low and short, and they arrive on a line that has no relation to the local clock. The block brings that line into its own clock domain and reacts to each falling edge. A timer then places every pulse either at the boundary of a bit cell or in its centre. A pulse in the centre of a cell means a one. A cell with only a boundary pulse, or with no pulse at all, means a zero.

Byte boundaries cannot be seen in the bit stream itself. They are set by a sync byte of value 0xA1 that has been written with one boundary pulse left out on purpose. Until the first such mark arrives, the block outputs nothing. When a mark is recognised, the block outputs the mark byte with a mark flag. Every following group of eight bits then goes out as a byte, most significant bit first, with a single-cycle valid strobe.

The length of a bit cell is given in local clock cycles. The default of 500 cycles at 125 MHz gives the 4 µs cell of the double-density format.

Top module: `mfm_read_decoder`

## Requirements
- R1: While reset is asserted, and after it until the first byte is produced, byteValid, byteData and byteIsMark are all 0.
- R2: No byte is reported before the first sync mark, whatever bits are decoded before it.
- R3: A sync mark is recognised when the last eight decoded bits are 0xA1 and the boundary pulse of bit index 5 is missing (bits counted from the MSB at index 0). Every other boundary pulse matches the encoding rule. The mark is reported as byteData 0xA1 with byteIsMark 1.
- R4: An 0xA1 byte that carries all its boundary pulses is not a mark. Before framing it produces no output. After framing it is reported as ordinary data with byteIsMark 0.
- R5: After a mark, each following group of eight bits is reported as one byte, first-received bit in byteData[7], with byteIsMark 0.
- R6: A mark restarts byte framing at whatever bit position it ends. Bits decoded before the mark still complete the frame that was open. A byte that finishes on the same bit as the mark is not reported separately.
- R7: byteValid is high for exactly one clock cycle per reported byte.
- R8: A pulse between one quarter and three quarters of the cell after the cell start decodes as 1. A cell with only a start pulse, or with no pulse, decodes as 0.
- R9: The first falling edge after reset is taken as a cell-start pulse, however long the line was idle before it.
- R10: Pulses displaced from their nominal positions by less than a quarter cell still decode correctly, because each pulse re-aligns the cell timer.
- R11: Each falling edge of the input counts as one pulse, whatever the pulse width, up to about a third of a cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock that also times the bit cells |
| rstN | input | 1 | Synchronous active-low reset |
| pulseN | input | 1 | Raw active-low read pulses, asynchronous to clk |
| byteValid | output | 1 | One-cycle strobe, a byte is present on byteData |
| byteData | output | 8 | Decoded byte, first-received bit in bit 7 |
| byteIsMark | output | 1 | Set with byteValid when the byte is a sync mark |

## Verification
The embedded properties check on every cycle the rules that do not depend on bit values:
- the valid strobe lasts a single cycle and always follows a bit event;
- a flagged byte always carries 0xA1;
- an unframed decoder stays silent;
- the first edge after reset becomes a boundary pulse;
- a synchronised edge is never seen twice in a row.

Only the directed scenarios can show that bit values are right. These include:
- whole identifiers after two marks;
- an 0xA1 that is written with all its boundary pulses and so is not a mark;
- re-framing when a mark arrives three bits off the old frame;
- jittered placement of pulses;
- pulses much wider than nominal.

// File: rtl/mfm_rd_pkg.sv
`timescale 1ns/1ps
package mfm_rd_pkg;

  localparam int BYTE_W = 8;

  // One decoded bit cell, handed from the timing control to the framer.
  typedef struct packed {
    logic bitStrobe;   // a cell has just closed
    logic bitVal;      // centre pulse seen in that cell
    logic clkSeen;     // boundary pulse seen in that cell
  } cellEvt_t;

  // Boundary-pulse pattern that the encoding rule gives a byte, index 0 in bit 7.
  function automatic logic [BYTE_W-1:0] clockPattern(input logic [BYTE_W-1:0] dataByte,
                                                     input logic priorBit);
    logic [BYTE_W-1:0] pat;
    logic prev;
    prev = priorBit;
    for (int i = 0; i < BYTE_W; i++) begin
      pat[BYTE_W-1-i] = !prev && !dataByte[BYTE_W-1-i];
      prev = dataByte[BYTE_W-1-i];
    end
    return pat;
  endfunction

endpackage

// File: rtl/mfm_rd_timing.sv
`timescale 1ns/1ps
module mfm_rd_timing
  import mfm_rd_pkg::*;
#(
  parameter int CELL_CYC    = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pulseN,
  output cellEvt_t evt
);

  localparam int TW = $clog2(CELL_CYC);
  localparam logic [TW-1:0] QTR_T  = TW'(CELL_CYC / 4);
  localparam logic [TW-1:0] HALF_T = TW'(CELL_CYC / 2);
  localparam logic [TW-1:0] LATE_T = TW'((3 * CELL_CYC) / 4);
  localparam logic [TW-1:0] LAST_T = TW'(CELL_CYC - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic pulseDly;
  logic fallEdge;
  logic [TW-1:0] timer;
  logic acquired;
  logic clkFlag, dataFlag;
  logic inDataWin, isData, isClk, emit;

  // Input synchroniser and falling-edge detector.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= '1;
      pulseDly <= 1'b1;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], pulseN};
      pulseDly <= syncQ[SYNC_STAGES-1];
    end
  end

  assign fallEdge  = pulseDly && !syncQ[SYNC_STAGES-1];
  assign inDataWin = (timer >= QTR_T) && (timer < LATE_T);
  assign isData    = fallEdge && acquired && inDataWin;
  assign isClk     = fallEdge && !isData;
  assign emit      = acquired && (timer == LATE_T);

  // Cell timer: free-runs once acquired, re-aligned by every pulse.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer    <= '0;
      acquired <= 1'b0;
      clkFlag  <= 1'b0;
      dataFlag <= 1'b0;
      evt      <= '0;
    end else begin
      if (fallEdge) begin
        acquired <= 1'b1;
        timer    <= isData ? HALF_T + 1'b1 : TW'(1);
      end else if (acquired) begin
        timer <= (timer == LAST_T) ? '0 : timer + 1'b1;
      end
      clkFlag       <= (emit ? 1'b0 : clkFlag)  | isClk;
      dataFlag      <= (emit ? 1'b0 : dataFlag) | isData;
      evt.bitStrobe <= emit;
      evt.bitVal    <= dataFlag;
      evt.clkSeen   <= clkFlag;
    end
  end

  p_edge_isolated_r11: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge |=> !fallEdge);

  p_first_pulse_clock_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge && !acquired) |=> (clkFlag && !dataFlag && acquired));

  p_cell_event_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    evt.bitStrobe |=> !evt.bitStrobe);

endmodule

// File: rtl/mfm_rd_framer.sv
`timescale 1ns/1ps
module mfm_rd_framer
  import mfm_rd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'hA1,
  parameter logic [BYTE_W-1:0] SYNC_CLK  = 8'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  cellEvt_t          evt,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteIsMark
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] dataSr, clkSr, dataNext, clkNext;
  logic [CNT_W-1:0]  bitCnt;
  logic framed, markHit, byteDone;

  assign dataNext = {dataSr[BYTE_W-2:0], evt.bitVal};
  assign clkNext  = {clkSr[BYTE_W-2:0], evt.clkSeen};
  assign markHit  = evt.bitStrobe && (dataNext == SYNC_BYTE) && (clkNext == SYNC_CLK);
  assign byteDone = evt.bitStrobe && framed && (bitCnt == CNT_LAST) && !markHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataSr     <= '0;
      clkSr      <= '0;
      bitCnt     <= '0;
      framed     <= 1'b0;
      byteValid  <= 1'b0;
      byteIsMark <= 1'b0;
      byteData   <= '0;
    end else begin
      byteValid  <= markHit || byteDone;
      byteIsMark <= markHit;
      if (markHit || byteDone) byteData <= dataNext;
      if (evt.bitStrobe) begin
        dataSr <= dataNext;
        clkSr  <= clkNext;
        if (markHit) begin
          framed <= 1'b1;
          bitCnt <= '0;
        end else if (framed) begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  p_mark_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteIsMark |-> (byteValid && byteData == SYNC_BYTE));

  p_valid_after_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(evt.bitStrobe));

  p_unframed_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!framed && !markHit) |=> !byteValid);

endmodule

// File: rtl/mfm_read_decoder.sv
`timescale 1ns/1ps
module mfm_read_decoder
  import mfm_rd_pkg::*;
#(
  parameter int                CELL_CYC    = 500,
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] SYNC_BYTE   = 8'hA1,
  parameter int                GAP_IDX     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseN,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteIsMark
);

  localparam logic [BYTE_W-1:0] GAP_MASK = (BYTE_W)'(1) << (BYTE_W - 1 - GAP_IDX);
  localparam logic [BYTE_W-1:0] SYNC_CLK = clockPattern(SYNC_BYTE, 1'b0) & ~GAP_MASK;

  cellEvt_t cellEvt;

  mfm_rd_timing #(
    .CELL_CYC   (CELL_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_timing (
    .clk   (clk),
    .rstN  (rstN),
    .pulseN(pulseN),
    .evt   (cellEvt)
  );

  mfm_rd_framer #(
    .SYNC_BYTE(SYNC_BYTE),
    .SYNC_CLK (SYNC_CLK)
  ) u_framer (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (cellEvt),
    .byteValid (byteValid),
    .byteData  (byteData),
    .byteIsMark(byteIsMark)
  );

endmodule

// File: tb/mfm_read_decoder_tb.sv
`timescale 1ns/1ps
module mfm_read_decoder_tb;

  localparam int CELL = 80;
  localparam int HALF = CELL / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pulseN = 1'b1;
  logic byteValid;
  logic [7:0] byteData;
  logic byteIsMark;

  always #4 clk = ~clk;

  mfm_read_decoder #(.CELL_CYC(CELL)) u_dut (
    .clk(clk), .rstN(rstN), .pulseN(pulseN),
    .byteValid(byteValid), .byteData(byteData), .byteIsMark(byteIsMark)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  int gotN = 0;
  logic [7:0] gotD [64];
  logic       gotM [64];
  int expN = 0;
  logic [7:0] expD [64];
  logic       expM [64];
  int runLen = 0;
  int maxRun = 0;

  int jitAmp = 0;
  int pw = 6;
  int cellIdx = 0;
  logic prevBit = 1'b0;

  always @(negedge clk) begin
    if (rstN && byteValid) begin
      if (gotN < 64) begin
        gotD[gotN] = byteData;
        gotM[gotN] = byteIsMark;
      end
      gotN++;
      runLen++;
      if (runLen > maxRun) maxRun = runLen;
    end else begin
      runLen = 0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp_);
    nChecks++;
    if (act !== exp_) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_);
    end
  endtask

  task automatic expByte(input logic [7:0] d, input logic m);
    expD[expN] = d;
    expM[expN] = m;
    expN++;
  endtask

  task automatic compareStream(input string req);
    chk(req, "byte count", gotN, expN);
    for (int i = 0; i < expN; i++) begin
      if (i < gotN && i < 64) begin
        chk(req, $sformatf("byte %0d value", i), gotD[i], expD[i]);
        chk(req, $sformatf("byte %0d mark flag", i), gotM[i], expM[i]);
      end
    end
  endtask

  task automatic doReset();
    pulseN = 1'b1;
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    gotN = 0;
    expN = 0;
    prevBit = 1'b0;
    cellIdx = 0;
    jitAmp = 0;
    pw = 6;
  endtask

  task automatic sendCell(input logic clkP, input logic datP);
    int cOff, dOff;
    cOff = (jitAmp == 0) ? 0 : (cellIdx * 3) % (jitAmp + 1);
    dOff = (jitAmp == 0) ? 0 : (cellIdx * 5 + 2) % (jitAmp + 1);
    cellIdx++;
    for (int c = 0; c < CELL; c++) begin
      @(negedge clk);
      pulseN = !((clkP && c >= cOff && c < cOff + pw) ||
                 (datP && c >= HALF + dOff && c < HALF + dOff + pw));
    end
  endtask

  task automatic sendBit(input logic b, input logic allowClk);
    sendCell(!prevBit && !b && allowClk, b);
    prevBit = b;
  endtask

  // gap < 0: every boundary pulse present; otherwise drop the one at that bit index
  task automatic sendByte(input logic [7:0] b, input int gap);
    for (int i = 0; i < 8; i++) sendBit(b[7-i], i != gap);
  endtask

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) sendByte(8'h00, -1);
  endtask

  task automatic settle();
    repeat (25) @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    pulseN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "byteValid in reset", byteValid, 0);
    chk("R1", "byteData in reset", byteData, 0);
    chk("R1", "byteIsMark in reset", byteIsMark, 0);
    doReset();
    repeat (200) @(negedge clk);
    chk("R1", "byteValid idle", byteValid, 0);
    chk("R1", "byteData idle", byteData, 0);
    chk("R1", "no bytes while idle", gotN, 0);
  endtask

  task automatic testBasicFrame();
    doReset();
    repeat (37) @(negedge clk);   // R9: arbitrary idle before the first edge
    preamble(3);
    chk("R2", "bytes before mark", gotN, 0);
    sendByte(8'hA1, 5);
    sendByte(8'hA1, 5);
    sendByte(8'h30, -1);
    sendByte(8'h31, -1);
    sendByte(8'h32, -1);
    sendByte(8'h33, -1);
    settle();
    expByte(8'hA1, 1); expByte(8'hA1, 1);
    expByte(8'h30, 0); expByte(8'h31, 0); expByte(8'h32, 0); expByte(8'h33, 0);
    compareStream("R3 R5 R9");
  endtask

  task automatic testPlainA1();
    doReset();
    preamble(3);
    sendByte(8'hA1, -1);
    sendByte(8'h00, -1);
    chk("R4", "plain A1 unframed output", gotN, 0);
    sendByte(8'hA1, 5);
    sendByte(8'hA1, -1);
    sendByte(8'hFF, -1);
    sendByte(8'h55, -1);
    sendByte(8'h00, -1);
    settle();
    expByte(8'hA1, 1); expByte(8'hA1, 0);
    expByte(8'hFF, 0); expByte(8'h55, 0); expByte(8'h00, 0);
    compareStream("R4 R8");
  endtask

  task automatic testRealign();
    doReset();
    preamble(3);
    sendByte(8'hA1, 5);
    sendByte(8'h30, -1);
    sendBit(1'b1, 1'b1);
    sendBit(1'b0, 1'b1);
    sendBit(1'b1, 1'b1);
    sendByte(8'hA1, 5);
    sendByte(8'h42, -1);
    settle();
    // three stray bits 101 plus the mark's first five bits 10100 close the old frame
    expByte(8'hA1, 1); expByte(8'h30, 0); expByte(8'hB4, 0);
    expByte(8'hA1, 1); expByte(8'h42, 0);
    compareStream("R6");
  endtask

  task automatic testJitter();
    doReset();
    jitAmp = 8;
    preamble(4);
    sendByte(8'hA1, 5);
    sendByte(8'hA1, 5);
    sendByte(8'h30, -1); sendByte(8'h31, -1); sendByte(8'h32, -1);
    sendByte(8'h33, -1); sendByte(8'h91, -1); sendByte(8'h16, -1);
    settle();
    expByte(8'hA1, 1); expByte(8'hA1, 1);
    expByte(8'h30, 0); expByte(8'h31, 0); expByte(8'h32, 0);
    expByte(8'h33, 0); expByte(8'h91, 0); expByte(8'h16, 0);
    compareStream("R10");
  endtask

  task automatic testWidePulse();
    doReset();
    pw = 25;
    preamble(3);
    sendByte(8'hA1, 5);
    sendByte(8'h00, -1);
    sendByte(8'h55, -1);
    sendByte(8'hFF, -1);
    settle();
    expByte(8'hA1, 1); expByte(8'h00, 0); expByte(8'h55, 0); expByte(8'hFF, 0);
    compareStream("R11");
  endtask

  initial begin
    testReset();
    testBasicFrame();
    testPlainA1();
    testRealign();
    testJitter();
    testWidePulse();
    chk("R7", "longest byteValid run", maxRun, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL R5 watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule